// File: doc/BRIEF.md
# Read-Ahead Polynomial Streamer with In-Place Write-Back

This block moves polynomials of 256 coefficients between a coefficient memory and a transform core. The memory has a single registered read port, so each read returns its data one cycle after the address. To hide that latency, the streamer keeps its read pointer one cycle ahead of the coefficient the core is taking and delays the core-side valid by one cycle. The core must keep its ready high for the whole load, so the skew is fixed and the streamer does not gate on backpressure.

While the core computes, the streamer waits for the core's result stream. Every result is written back to the same polynomial slot it came from, at an index that advances with each result. After the last result of a slot, the streamer waits until the core is idle (ready high and done low) and then primes the load of the next slot. A start command gives a slot count, and the slots are handled in ascending order from the bottom of the region. The first half is typically one family of polynomials and the second half another. A single-cycle done pulse closes the stage.

Top module: `poly_readahead_streamer`

## Requirements
- R1: While loading slot s, the block presents read addresses s*256+i for i = 0..255 in ascending order, one per cycle with read enable high. The address is the slot number in the upper bits and the coefficient index in the lower 8 bits. There are exactly 256 read cycles per slot.
- R2: In every cycle with core valid high, core data equals the memory word read by the address of the previous cycle. The core therefore receives memory[s*256+i] for i = 0..255 in order.
- R3: Core valid is high in a cycle exactly when read enable was high in the cycle before. It is low in the first read cycle of every slot and drops right after the 256th coefficient.
- R4: A slot load starts only when a slot is pending, core ready is high and core done is low. No read is issued while core done is high.
- R5: Each core result is written one cycle after it arrives, with its data unchanged. The k-th result of slot s goes to address s*256+k.
- R6: The write index wraps from 255 to 0 after the last result of a slot, so the next slot writes start at index 0.
- R7: A run with slot count n (1..8) processes slots 0..n-1 in order and leaves all words at addresses from n*256 upward unchanged.
- R8: Done is a one-cycle pulse in the cycle after the last write of the last slot. Busy goes high after an accepted start and drops in the same cycle as done.
- R9: A start is ignored while busy, or when the slot count is 0 or above 8. An ignored start leaves busy low when idle and does not change the count of a run in progress.
- R10: After reset, busy, done, read enable, write enable and core valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a stage (accepted only when idle) |
| slot_cnt_i | input | 4 | Number of slots to process, 1..8 |
| busy_o | output | 1 | Stage in progress |
| done_o | output | 1 | One-cycle end-of-stage pulse |
| mem_re_o | output | 1 | Memory read enable |
| mem_raddr_o | output | 11 | Memory read address {slot, index} |
| mem_rdata_i | input | 12 | Registered memory read data |
| mem_we_o | output | 1 | Memory write enable |
| mem_waddr_o | output | 11 | Memory write address {slot, index} |
| mem_wdata_o | output | 12 | Memory write data |
| core_valid_o | output | 1 | Coefficient valid toward the core |
| core_data_o | output | 12 | Coefficient toward the core |
| core_ready_i | input | 1 | Core can accept a load |
| core_ovalid_i | input | 1 | Core result valid |
| core_odata_i | input | 12 | Core result coefficient |
| core_done_i | input | 1 | Core finished its output burst |

## Verification
The hardest case to reach from the ports is the handover between slots. The last result of one slot has just been written, the core is still raising done, and the next prime must wait for done to clear. The bench drives this with a behavioural core that holds done high for one to three cycles, chosen per run. It flags any read issued in those cycles, and it checks that valid returns low on the first read of each new slot. Sweeping the slot count from 1 to 8 also covers the wrap of the write index at every slot boundary, and the untouched region above the last slot.

// File: rtl/psr_pkg.sv
package psr_pkg;

  // Stage sequencing phases of the streamer.
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // no stage running
    PH_PEND = 2'd1,  // a slot is waiting for the core to become idle
    PH_RUN  = 2'd2   // slot loaded or in flight, awaiting its results
  } psr_phase_e;

endpackage

// File: rtl/psr_sequencer.sv
module psr_sequencer
  import psr_pkg::*;
#(
  parameter int SLOTS_MAX = 8,
  parameter int SLOT_W    = 3,
  parameter int SC_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [SC_W-1:0]   slot_cnt_i,
  input  logic              core_ready_i,
  input  logic              core_done_i,
  input  logic              wr_last_i,
  output logic              prime_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              busy_o,
  output logic              done_o
);

  psr_phase_e          phase_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [SC_W-1:0]     last_q;
  logic                done_q;
  logic                accept;
  logic                at_last;

  assign accept  = start_i && (phase_q == PH_IDLE) && (slot_cnt_i != '0)
                   && (slot_cnt_i <= SC_W'(SLOTS_MAX));
  assign prime_o = (phase_q == PH_PEND) && core_ready_i && !core_done_i;
  assign at_last = (SC_W'(slot_q) == last_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      slot_q  <= '0;
      last_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            slot_q  <= '0;
            last_q  <= slot_cnt_i - SC_W'(1);
            phase_q <= PH_PEND;
          end
        end
        PH_PEND: begin
          if (prime_o) phase_q <= PH_RUN;
        end
        PH_RUN: begin
          if (wr_last_i) begin
            if (at_last) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end else begin
              slot_q  <= slot_q + SLOT_W'(1);
              phase_q <= PH_PEND;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign slot_o = slot_q;
  assign busy_o = (phase_q != PH_IDLE);
  assign done_o = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R8
  AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (SC_W'(slot_q) <= last_q)); // R7
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(last_q)); // R9

endmodule

// File: rtl/psr_load_ptr.sv
module psr_load_ptr #(
  parameter int N_COEF = 256,
  parameter int IDX_W  = 8,
  parameter int SLOT_W = 3,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prime_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              valid_o
);

  // Pointer runs from 0 to N_COEF; its top bit marks the end of the load.
  logic [IDX_W:0] ptr_q;
  logic           loading_q;
  logic           valid_q;
  logic           rd_en;

  assign rd_en = loading_q && !ptr_q[IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q     <= '0;
      loading_q <= 1'b0;
      valid_q   <= 1'b0;
    end else if (prime_i) begin
      ptr_q     <= '0;
      loading_q <= 1'b1;
      valid_q   <= 1'b0;
    end else if (loading_q) begin
      if (ptr_q[IDX_W]) begin
        loading_q <= 1'b0;
        valid_q   <= 1'b0;
      end else begin
        ptr_q   <= ptr_q + (IDX_W+1)'(1);
        valid_q <= 1'b1;
      end
    end
  end

  assign rd_en_o   = rd_en;
  assign rd_addr_o = {slot_i, ptr_q[IDX_W-1:0]};
  assign valid_o   = valid_q;

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= (IDX_W+1)'(N_COEF)); // R1
  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> $past(rd_en)); // R2
  AST_PRIME_VALID_LOW: assert property (@(posedge clk) disable iff (rst)
    prime_i |=> !valid_q); // R3

endmodule

// File: rtl/psr_writeback.sv
module psr_writeback #(
  parameter int N_COEF = 256,
  parameter int IDX_W  = 8,
  parameter int SLOT_W = 3,
  parameter int ADDR_W = 11,
  parameter int COEF_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              res_valid_i,
  input  logic [COEF_W-1:0] res_data_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [COEF_W-1:0] wdata_o,
  output logic              wr_last_o
);

  logic [IDX_W-1:0]  widx_q;
  logic              we_q;
  logic              last_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [COEF_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      widx_q <= '0;
      we_q   <= 1'b0;
      last_q <= 1'b0;
    end else begin
      we_q   <= res_valid_i;
      last_q <= res_valid_i && (widx_q == IDX_W'(N_COEF-1));
      if (res_valid_i) widx_q <= widx_q + IDX_W'(1);
    end
  end

  // Data path without reset so it maps onto plain flops.
  always_ff @(posedge clk) begin
    if (res_valid_i) begin
      waddr_q <= {slot_i, widx_q};
      wdata_q <= res_data_i;
    end
  end

  assign we_o      = we_q;
  assign waddr_o   = waddr_q;
  assign wdata_o   = wdata_q;
  assign wr_last_o = last_q;

  AST_WRITE_FOLLOWS_RESULT: assert property (@(posedge clk) disable iff (rst)
    we_q |-> $past(res_valid_i)); // R5
  AST_INDEX_WRAP: assert property (@(posedge clk) disable iff (rst)
    (res_valid_i && (widx_q == IDX_W'(N_COEF-1))) |=> (widx_q == '0)); // R6

endmodule

// File: rtl/poly_readahead_streamer.sv
module poly_readahead_streamer #(
  parameter int COEF_W = 12,
  parameter int N_COEF = 256,
  parameter int K_MAX  = 4,
  localparam int IDX_W     = $clog2(N_COEF),
  localparam int SLOTS_MAX = 2 * K_MAX,
  localparam int SLOT_W    = $clog2(SLOTS_MAX),
  localparam int SC_W      = $clog2(SLOTS_MAX + 1),
  localparam int ADDR_W    = SLOT_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [SC_W-1:0]   slot_cnt_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [COEF_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [COEF_W-1:0] mem_wdata_o,
  output logic              core_valid_o,
  output logic [COEF_W-1:0] core_data_o,
  input  logic              core_ready_i,
  input  logic              core_ovalid_i,
  input  logic [COEF_W-1:0] core_odata_i,
  input  logic              core_done_i
);

  logic              prime;
  logic              wr_last;
  logic [SLOT_W-1:0] slot;

  psr_sequencer #(
    .SLOTS_MAX(SLOTS_MAX), .SLOT_W(SLOT_W), .SC_W(SC_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .start_i(start_i), .slot_cnt_i(slot_cnt_i),
    .core_ready_i(core_ready_i), .core_done_i(core_done_i),
    .wr_last_i(wr_last),
    .prime_o(prime), .slot_o(slot),
    .busy_o(busy_o), .done_o(done_o)
  );

  psr_load_ptr #(
    .N_COEF(N_COEF), .IDX_W(IDX_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)
  ) u_load (
    .clk(clk), .rst(rst),
    .prime_i(prime), .slot_i(slot),
    .rd_en_o(mem_re_o), .rd_addr_o(mem_raddr_o),
    .valid_o(core_valid_o)
  );

  psr_writeback #(
    .N_COEF(N_COEF), .IDX_W(IDX_W), .SLOT_W(SLOT_W),
    .ADDR_W(ADDR_W), .COEF_W(COEF_W)
  ) u_wb (
    .clk(clk), .rst(rst),
    .slot_i(slot),
    .res_valid_i(core_ovalid_i), .res_data_i(core_odata_i),
    .we_o(mem_we_o), .waddr_o(mem_waddr_o), .wdata_o(mem_wdata_o),
    .wr_last_o(wr_last)
  );

  // The memory output register already aligns data with the delayed valid.
  assign core_data_o = mem_rdata_i;

endmodule

// File: tb/poly_readahead_streamer_tb.sv
module poly_readahead_streamer_tb;

  localparam int LAT = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  slot_cnt = 4'd0;
  logic        busy, done, re, we, cvalid;
  logic [10:0] raddr, waddr;
  logic [11:0] rdata, wdata, cdata;
  logic        c_ready, c_ov, c_done;
  logic [11:0] c_od;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  poly_readahead_streamer u_dut (
    .clk(clk), .rst(rst), .start_i(start), .slot_cnt_i(slot_cnt),
    .busy_o(busy), .done_o(done),
    .mem_re_o(re), .mem_raddr_o(raddr), .mem_rdata_i(rdata),
    .mem_we_o(we), .mem_waddr_o(waddr), .mem_wdata_o(wdata),
    .core_valid_o(cvalid), .core_data_o(cdata),
    .core_ready_i(c_ready), .core_ovalid_i(c_ov), .core_odata_i(c_od),
    .core_done_i(c_done)
  );

  function automatic logic [11:0] ini(int a, int r);
    return 12'((a * 37 + 11 + r * 101) & 12'hFFF);
  endfunction

  function automatic logic [11:0] xf(logic [11:0] x, int k);
    return 12'((int'(x) * 5 + k * 3 + 1) & 12'hFFF);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Memory model: one-cycle registered read, one write port.
  logic [11:0] mem [0:2047];
  always @(posedge clk) begin
    if (re) rdata <= mem[raddr];
    if (we) mem[waddr] <= wdata;
  end

  // Behavioural transform core.
  logic [11:0] inbuf [0:255];
  int cst, ccnt, hcnt;
  int hold_cyc = 1;
  always @(posedge clk) begin
    if (rst) begin
      cst <= 0; ccnt <= 0; hcnt <= 0;
      c_ready <= 1'b1; c_done <= 1'b0; c_ov <= 1'b0; c_od <= '0;
    end else begin
      case (cst)
        0: begin
          c_done <= 1'b0;
          if (cvalid) begin
            inbuf[ccnt] <= cdata;
            if (ccnt == 255) begin ccnt <= 0; c_ready <= 1'b0; cst <= 1; end
            else ccnt <= ccnt + 1;
          end
        end
        1: begin
          if (ccnt == LAT - 1) begin ccnt <= 0; cst <= 2; end
          else ccnt <= ccnt + 1;
        end
        2: begin
          c_ov <= 1'b1;
          c_od <= xf(inbuf[ccnt], ccnt);
          if (ccnt == 255) begin ccnt <= 0; hcnt <= 0; cst <= 3; end
          else ccnt <= ccnt + 1;
        end
        default: begin
          c_ov <= 1'b0; c_ready <= 1'b1; c_done <= 1'b1;
          if (hcnt == hold_cyc) begin c_done <= 1'b0; cst <= 0; end
          else hcnt <= hcnt + 1;
        end
      endcase
    end
  end

  // Monitor, sampled at the falling edge.
  int cur_r = 0;
  int m_rslot, m_ridx, m_vslot, m_vidx, m_wslot, m_widx;
  int cyc = 0, last_we_cyc = -10;
  bit prev_re = 1'b0, prev_done = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(cvalid == prev_re, "R3 valid follows read", cvalid, prev_re);
      if (re) begin
        chk(int'(raddr) == m_rslot * 256 + m_ridx, "R1 read address",
            raddr, m_rslot * 256 + m_ridx);
        chk(c_ready && !c_done, "R4 read while core not idle",
            {c_ready, c_done}, 2);
        m_ridx++;
        if (m_ridx == 256) begin m_ridx = 0; m_rslot++; end
      end
      if (cvalid) begin
        chk(cdata == ini(m_vslot * 256 + m_vidx, cur_r), "R2 core data",
            cdata, ini(m_vslot * 256 + m_vidx, cur_r));
        m_vidx++;
        if (m_vidx == 256) begin m_vidx = 0; m_vslot++; end
      end
      if (we) begin
        chk(int'(waddr) == m_wslot * 256 + m_widx, "R5 write address",
            waddr, m_wslot * 256 + m_widx);
        chk(wdata == xf(ini(m_wslot * 256 + m_widx, cur_r), m_widx),
            "R5 write data", wdata,
            xf(ini(m_wslot * 256 + m_widx, cur_r), m_widx));
        m_widx++;
        if (m_widx == 256) begin m_widx = 0; m_wslot++; end
        last_we_cyc = cyc;
      end
      if (done) begin
        chk(last_we_cyc == cyc - 1, "R8 done after last write",
            last_we_cyc, cyc - 1);
        chk(!busy, "R8 busy drops with done", busy, 0);
        chk(!prev_done, "R8 done single pulse", prev_done, 0);
      end
    end
    prev_re   = re;
    prev_done = done;
  end

  task automatic run(int n, int hold, int r);
    @(negedge clk);
    cur_r = r; hold_cyc = hold;
    for (int a = 0; a < 2048; a++) mem[a] = ini(a, r);
    m_rslot = 0; m_ridx = 0; m_vslot = 0; m_vidx = 0;
    m_wslot = 0; m_widx = 0;
    start = 1'b1; slot_cnt = 4'(n);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(busy, "R8 busy after start", busy, 1);
    repeat (300) @(negedge clk);
    // R9: a start during a run must not change its slot count
    start = 1'b1; slot_cnt = 4'(9 - n);
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(m_rslot == n && m_ridx == 0, "R1 slots read", m_rslot, n);
    chk(m_vslot == n && m_vidx == 0, "R3 valid count", m_vslot, n);
    chk(m_wslot == n && m_widx == 0, "R7 R9 slots written", m_wslot, n);
    for (int a = 0; a < 2048; a++) begin
      if (a < n * 256)
        chk(mem[a] == xf(ini(a, r), a % 256), "R6 R7 written back",
            mem[a], xf(ini(a, r), a % 256));
      else
        chk(mem[a] == ini(a, r), "R7 above region untouched",
            mem[a], ini(a, r));
    end
  endtask

  task automatic bad_start(int n);
    @(negedge clk);
    start = 1'b1; slot_cnt = 4'(n);
    @(negedge clk);
    start = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(!busy && !re && !cvalid, "R9 bad count ignored", busy, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !re && !we && !cvalid, "R10 reset state",
        {busy, done, re, we, cvalid}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !re && !we && !cvalid, "R10 idle after reset",
        {busy, done, re, we, cvalid}, 0);
    bad_start(0);
    bad_start(9);
    for (int n = 1; n <= 8; n++) run(n, (n % 3) + 1, n);
    bad_start(0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule